// File: doc/BRIEF.md
# Oversampling Serial Receiver with Noise Detection

This block receives asynchronous serial frames of one start bit, eight data bits (least significant first) and one stop bit. The serial line is examined once per pulse of a sample-enable input that runs at sixteen times the bit rate, so every bit period is divided into sixteen sample slots, numbered 1 to 16. A frame begins when a low sample follows a run of at least three high samples. The start bit is then confirmed by three early samples, and each later bit is decided by a two-out-of-three vote over three samples near its centre.

Any disagreement among the three samples of a bit, or a start bit accepted with one stray high sample, marks the frame as noisy. A stop bit that resolves low marks it as a framing error. To tolerate a bit rate that differs from the local sample rate, the slot counter restarts on every start edge. It is also realigned whenever a high data bit is followed by a low one, using the measured position of the falling edge between them. At the end of each frame the byte and both flags are presented with a one-cycle valid strobe.

Top module: `uart_os_rx`

## Requirements
- R1: While reset is asserted and after its release, valid_o, data_o, noise_o and frame_err_o are all 0 until a frame completes.
- R2: A frame starts only on a low sample that follows at least three consecutive high samples, and after each frame this count of high samples begins again from zero, so a line held low after a frame yields no further frame.
- R3: The start bit is confirmed from the samples in slots 3, 5 and 7 of the start bit. If two or three of them are high, the start is rejected, no frame is produced and the search for a start begins again.
- R4: An accepted start with all three check samples low adds no noise; an accepted start with exactly one high check sample sets noise_o for that frame.
- R5: Each data bit takes the majority value of its samples in slots 8, 9 and 10, and the first data bit received lands in data_o bit 0.
- R6: If the three samples of any data bit or of the stop bit are not all equal, noise_o is 1 for that frame; the frame's data value is still the majority result.
- R7: frame_err_o is 1 when the stop bit resolves to 0 and 0 when it resolves to 1; the byte is delivered in both cases.
- R8: valid_o is high for exactly one clock cycle per received frame, and data_o, noise_o and frame_err_o keep their values until the next frame completes.
- R9: When a data bit resolving 1 is followed by one resolving 0, the slot counter is realigned so that the first low sample after the high bit counts as slot 1; a byte whose high bits are stretched or shortened by 5 or 6 samples each is still received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample enable, one pulse per sample slot (16 per bit) |
| rxd_i | input | 1 | Serial line, idle high |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe when a frame completes |
| noise_o | output | 1 | Sample disagreement seen in the last frame |
| frame_err_o | output | 1 | Stop bit of the last frame resolved low |

## Verification
Noise detection and framing-error detection are separate decisions that land in the same output update, because both are settled by the stop bit's resolution. The bench provokes both in one frame by accepting a start bit with a single stray high check sample and then sending a low stop bit. It expects one strobe carrying the byte with both flags set. A second case puts the only disagreeing sample inside the stop bit itself, where the noise and frame decisions come from the same three samples: noise must be set while the framing flag stays clear.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  localparam int unsigned OSR  = 16;
  localparam int unsigned RT_W = $clog2(OSR + 1);

  localparam logic [RT_W-1:0] RT_ONE  = RT_W'(1);
  localparam logic [RT_W-1:0] RT_LAST = RT_W'(OSR);
  // start confirmation slots
  localparam logic [RT_W-1:0] RT_S0 = RT_W'(3);
  localparam logic [RT_W-1:0] RT_S1 = RT_W'(5);
  localparam logic [RT_W-1:0] RT_S2 = RT_W'(7);
  // bit decision slots
  localparam logic [RT_W-1:0] RT_D0 = RT_W'(8);
  localparam logic [RT_W-1:0] RT_D1 = RT_W'(9);
  localparam logic [RT_W-1:0] RT_D2 = RT_W'(10);

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)   ff_q <= '1;
        else if (en_i) ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)   ff_q <= '1;
        else if (en_i) ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_os_rx_vote.sv
module uart_os_rx_vote (
  input  logic [2:0] smp_i,
  output logic       maj_o,
  output logic       noise_o
);
  always_comb begin
    maj_o   = (smp_i[0] & smp_i[1]) | (smp_i[0] & smp_i[2]) | (smp_i[1] & smp_i[2]);
    noise_o = (|smp_i) & ~(&smp_i);
  end
endmodule

// File: rtl/uart_os_rx_edge.sv
// Counts samples since the first low sample after a high bit resolved.
module uart_os_rx_edge
  import uart_os_rx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            arm_i,
  input  logic            clr_i,
  input  logic            rxs_i,
  output logic [RT_W-1:0] zcnt_o
);
  logic            armed_q;
  logic [RT_W-1:0] zcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      zcnt_q  <= '0;
    end else if (en_i) begin
      if (clr_i) begin
        armed_q <= 1'b0;
        zcnt_q  <= '0;
      end else if (arm_i) begin
        armed_q <= 1'b1;
        zcnt_q  <= '0;
      end else if (armed_q && (zcnt_q != '0 || !rxs_i) && zcnt_q != RT_LAST) begin
        zcnt_q <= zcnt_q + RT_ONE;
      end
    end
  end

  assign zcnt_o = zcnt_q;
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HUNT_ONES   = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 rxd_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 noise_o,
  output logic                 frame_err_o
);
  localparam int unsigned IDX_W  = $clog2(DATA_BITS + 1);
  localparam int unsigned ONES_W = $clog2(HUNT_ONES + 1);
  localparam logic [IDX_W-1:0]  IDX_STOP = IDX_W'(DATA_BITS);
  localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(HUNT_ONES);

  logic                 rxs;
  rx_state_e            state_q;
  logic [RT_W-1:0]      rt_q, slot_nx, resync_rt, zcnt;
  logic [ONES_W-1:0]    ones_q;
  logic [IDX_W-1:0]     bit_idx_q;
  logic [1:0]           smp_q;
  logic                 noise_q, done_q, prev_one_q;
  logic [DATA_BITS-1:0] shreg_q, data_q;
  logic                 valid_q, noise_out_q, ferr_q;
  logic                 maj, nz, resolve, arm, clr;

  uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tick_i),
    .d_i   (rxd_i),
    .q_o   (rxs)
  );

  uart_os_rx_vote u_vote (
    .smp_i  ({smp_q[0], smp_q[1], rxs}),
    .maj_o  (maj),
    .noise_o(nz)
  );

  always_comb begin
    slot_nx = (rt_q == RT_LAST) ? RT_ONE : rt_q + RT_ONE;
    resolve = tick_i && state_q == ST_DATA && !done_q && slot_nx == RT_D2;
    arm     = resolve && maj && bit_idx_q != IDX_STOP;
    clr     = state_q != ST_DATA;
    if (zcnt == '0)           resync_rt = slot_nx;
    else if (zcnt == RT_LAST) resync_rt = RT_LAST;
    else                      resync_rt = zcnt + RT_ONE;
  end

  uart_os_rx_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tick_i),
    .arm_i (arm),
    .clr_i (clr),
    .rxs_i (rxs),
    .zcnt_o(zcnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HUNT;
      rt_q        <= '0;
      ones_q      <= '0;
      bit_idx_q   <= '0;
      smp_q       <= '0;
      noise_q     <= 1'b0;
      done_q      <= 1'b0;
      prev_one_q  <= 1'b0;
      shreg_q     <= '0;
      data_q      <= '0;
      valid_q     <= 1'b0;
      noise_out_q <= 1'b0;
      ferr_q      <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tick_i) begin
        case (state_q)
          ST_HUNT: begin
            if (!rxs && ones_q == ONES_MAX) begin
              state_q <= ST_START;
              rt_q    <= RT_ONE;
              ones_q  <= '0;
              noise_q <= 1'b0;
            end else if (!rxs) begin
              ones_q <= '0;
            end else if (ones_q != ONES_MAX) begin
              ones_q <= ones_q + 1'b1;
            end
          end
          ST_START: begin
            rt_q <= slot_nx;
            if (slot_nx == RT_S0) smp_q[0] <= rxs;
            if (slot_nx == RT_S1) smp_q[1] <= rxs;
            if (slot_nx == RT_S2) begin
              if (maj) begin
                state_q <= ST_HUNT;
                ones_q  <= '0;
              end else begin
                noise_q <= nz;
              end
            end
            if (slot_nx == RT_LAST) begin
              state_q    <= ST_DATA;
              bit_idx_q  <= '0;
              done_q     <= 1'b0;
              prev_one_q <= 1'b0;
            end
          end
          ST_DATA: begin
            rt_q <= slot_nx;
            if (slot_nx == RT_ONE) done_q <= 1'b0;
            if (!done_q) begin
              if (slot_nx == RT_D0) smp_q[0] <= rxs;
              if (slot_nx == RT_D1) smp_q[1] <= rxs;
              if (slot_nx == RT_D2) begin
                done_q  <= 1'b1;
                noise_q <= noise_q | nz;
                if (bit_idx_q != IDX_STOP) begin
                  shreg_q    <= {maj, shreg_q[DATA_BITS-1:1]};
                  prev_one_q <= maj;
                  bit_idx_q  <= bit_idx_q + 1'b1;
                  if (prev_one_q && !maj) rt_q <= resync_rt;
                end else begin
                  data_q      <= shreg_q;
                  valid_q     <= 1'b1;
                  noise_out_q <= noise_q | nz;
                  ferr_q      <= ~maj;
                  state_q     <= ST_HUNT;
                  ones_q      <= '0;
                end
              end
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end

  assign data_o      = data_q;
  assign valid_o     = valid_q;
  assign noise_o     = noise_out_q;
  assign frame_err_o = ferr_q;
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk
  import uart_os_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned HUNT_ONES = 3,
  parameter int unsigned IDX_W     = $clog2(DATA_BITS + 1),
  parameter int unsigned ONES_W    = $clog2(HUNT_ONES + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic                 valid_i,
  input logic [DATA_BITS-1:0] data_i,
  input rx_state_e            state_i,
  input logic [RT_W-1:0]      rt_i,
  input logic [ONES_W-1:0]    ones_i,
  input logic [IDX_W-1:0]     bit_idx_i,
  input logic                 rxs_i
);
  AST_START_AFTER_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_START && $past(state_i) == ST_HUNT) |-> ($past(ones_i) == ONES_W'(HUNT_ONES) && !$past(rxs_i))); // R2

  AST_VALID_FROM_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(state_i) == ST_DATA); // R3

  AST_VALID_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(tick_i)); // R8

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i); // R8

  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(data_i)); // R8

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != ST_HUNT |-> (rt_i >= RT_ONE && rt_i <= RT_LAST)); // R9

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_idx_i <= IDX_W'(DATA_BITS)); // R5
endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_BITS(DATA_BITS), .HUNT_ONES(HUNT_ONES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .valid_i  (valid_o),
  .data_i   (data_o),
  .state_i  (state_q),
  .rt_i     (rt_q),
  .ones_i   (ones_q),
  .bit_idx_i(bit_idx_q),
  .rxs_i    (rxs)
);

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] data;
  logic       valid, noise, ferr;

  int checks = 0;
  int errors = 0;
  int vcnt = 0;
  int tcnt = 0;
  bit finished = 0;
  logic [7:0] cap_d;
  logic       cap_n, cap_f;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    tick = (tcnt == 0);
  end

  uart_os_rx u_uart_os_rx (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .rxd_i      (rxd),
    .data_o     (data),
    .valid_o    (valid),
    .noise_o    (noise),
    .frame_err_o(ferr)
  );

  always @(negedge clk) begin
    if (valid) begin
      vcnt++;
      cap_d = data;
      cap_n = noise;
      cap_f = ferr;
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v);
    rxd = v;
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1);
  endtask

  // p = {slot3, slot5, slot7}; rejected starts return the line high after slot 7
  task automatic start_seq(input logic [2:0] p);
    bit rej = ($countones(p) >= 2);
    for (int k = 1; k <= 16; k++) begin
      logic v = 1'b0;
      if (k == 3) v = p[2];
      if (k == 5) v = p[1];
      if (k == 7) v = p[0];
      if (rej && k > 7) v = 1'b1;
      drive(v);
    end
  endtask

  task automatic bits(input logic [7:0] d, input int l1, input int l0,
                      input logic stopv, input int fbit, input int fslot);
    for (int b = 0; b <= 8; b++) begin
      logic v = (b < 8) ? d[b] : stopv;
      int len = (b == 8) ? 16 : (v ? l1 : l0);
      for (int s = 1; s <= len; s++) drive((b == fbit && s == fslot) ? ~v : v);
    end
  endtask

  task automatic expect_frame(input string tag, input int v0, input logic [7:0] d,
                              input logic n, input logic f);
    check_eq({tag, " frame count"}, vcnt, v0 + 1);
    check_eq({tag, " data"}, cap_d, d);
    check_eq({tag, " noise"}, cap_n, n);
    check_eq({tag, " frame_err"}, cap_f, f);
  endtask

  task automatic t_reset;
    check_eq("R1 valid", valid, 0);
    check_eq("R1 data", data, 0);
    check_eq("R1 noise", noise, 0);
    check_eq("R1 frame_err", ferr, 0);
    idle(8);
    check_eq("R1 no frame while idle", vcnt, 0);
  endtask

  task automatic t_clean;
    logic [7:0] pats [4] = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
    foreach (pats[i]) begin
      int v0 = vcnt;
      idle(6);
      start_seq(3'b000);
      bits(pats[i], 16, 16, 1'b1, -1, 0);
      idle(12);
      expect_frame("R5 R7 clean byte", v0, pats[i], 1'b0, 1'b0);
    end
    idle(20);
    check_eq("R8 data held", data, 8'h3C);
    check_eq("R8 single strobe", vcnt, 4);
  endtask

  task automatic t_start_table;
    for (int p = 0; p < 8; p++) begin
      int v0 = vcnt;
      idle(6);
      start_seq(p[2:0]);
      if ($countones(p[2:0]) >= 2) begin
        idle(30);
        check_eq("R3 rejected start gives no frame", vcnt, v0);
      end else begin
        bits(8'h96, 16, 16, 1'b1, -1, 0);
        idle(12);
        expect_frame("R3 R4 accepted start", v0, 8'h96, ($countones(p[2:0]) == 1), 1'b0);
      end
    end
  endtask

  task automatic t_bit_noise;
    int v0 = vcnt;
    idle(6);
    start_seq(3'b000);
    bits(8'hC3, 16, 16, 1'b1, 3, 9);
    idle(12);
    expect_frame("R6 data bit noise", v0, 8'hC3, 1'b1, 1'b0);
    v0 = vcnt;
    idle(6);
    start_seq(3'b000);
    bits(8'h3C, 16, 16, 1'b1, 8, 8);
    idle(12);
    expect_frame("R6 R7 stop bit noise", v0, 8'h3C, 1'b1, 1'b0);
  endtask

  task automatic t_ferr;
    int v0 = vcnt;
    idle(6);
    start_seq(3'b000);
    bits(8'h5A, 16, 16, 1'b0, -1, 0);
    idle(16);
    expect_frame("R7 low stop", v0, 8'h5A, 1'b0, 1'b1);
    v0 = vcnt;
    idle(6);
    start_seq(3'b010);
    bits(8'h81, 16, 16, 1'b0, -1, 0);
    idle(16);
    expect_frame("R4 R7 noise with frame error", v0, 8'h81, 1'b1, 1'b1);
  endtask

  task automatic t_holdoff;
    int v0 = vcnt;
    idle(6);
    start_seq(3'b000);
    bits(8'h00, 16, 16, 1'b0, -1, 0);
    for (int i = 0; i < 40; i++) drive(1'b0);
    idle(30);
    expect_frame("R2 line low after frame", v0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_resync;
    int v0 = vcnt;
    idle(6);
    start_seq(3'b000);
    bits(8'h55, 22, 16, 1'b1, -1, 0);
    idle(12);
    expect_frame("R9 slow high bits", v0, 8'h55, 1'b0, 1'b0);
    v0 = vcnt;
    idle(6);
    start_seq(3'b000);
    bits(8'h55, 11, 16, 1'b1, -1, 0);
    idle(12);
    expect_frame("R9 fast high bits", v0, 8'h55, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=0x%0h expected=0x%0h", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_start_table();
    t_bit_noise();
    t_ferr();
    t_holdoff();
    t_resync();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule